// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block sits on the device side of an asynchronous DRAM interface. It samples the four active-low strobes (row strobe, column strobe, write enable, output enable) with a fast system clock. From the order in which their edges arrive it works out what kind of memory cycle the host is running. It captures the row and column addresses at the strobe falls. It runs its own refresh row counter for refresh cycles that take no address. It also tells the data-pin driver when the pins should be driven.

Classification depends on which edge came first, not on the level a strobe holds. Three cases show this: write enable falling before the column strobe, write enable falling after it, and the column strobe already low when the row strobe falls. The block also follows the case where the column strobe stays low across a new row-strobe pulse, which is a hidden refresh. Each finished cycle is reported with a one-clock event pulse and a three-bit type code. The block can serve as a protocol checker or as the front end of a small DRAM model.

Top module: `dram_cycle_decoder`

## Requirements
- R1: With row and column strobes both high, `dq_oe` is low. A column-strobe pulse while the row strobe stays high produces an event of type 0 (standby) on the clock after the column strobe rises.
- R2: Type codes are 0 standby, 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 row-only refresh, 6 column-before-row refresh, 7 hidden refresh. `evt_valid` is high for exactly one clock per finished cycle. It is high on the clock after both strobes are seen high, or on the clock after a row-strobe fall that closes the previous cycle while the column strobe is held low.
- R3: On a row-strobe fall with the column strobe high, `row_addr` takes `addr`. On the first column-strobe fall inside that cycle, `col_addr` takes `addr`. Later address changes leave both unchanged.
- R4: A row-strobe pulse in which the column strobe never falls is reported as type 5, and `dq_oe` stays low.
- R5: A row-strobe fall while the column strobe is already low is reported as type 6 (unless R11 applies). It loads `row_addr` from the refresh counter and ignores `addr`. It advances `ref_row` by one. `dq_oe` stays low.
- R6: In an access cycle with write enable high at the column fall, `dq_oe` goes high one clock after the column strobe and output enable are both seen low with write enable high. If write enable never falls, the cycle is type 1.
- R7: Output enable going high while the column strobe is still low drives `dq_oe` low on the next clock.
- R8: Write enable low at the column-strobe fall makes the cycle type 2, and `dq_oe` never goes high during it.
- R9: Write enable falling after the column strobe, when no data was driven in that access, makes the cycle type 3.
- R10: Write enable falling after data was driven in that access makes the cycle type 4.
- R11: After an access, if the row strobe rises and falls again while the column strobe stays low, the access event is reported at that second fall. `dq_oe` keeps its held state. A type 7 event follows when both strobes are high, and `ref_row` advances by one.
- R12: `proto_err` pulses for one clock when write enable changes while `dq_oe` is high.
- R13: `ref_row` is 0 after reset, is ADDR_W bits wide, and wraps from its maximum to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sampling clock |
| rst_n | input | 1 | asynchronous active-low reset |
| ras_n | input | 1 | row strobe, active low |
| cas_n | input | 1 | column strobe, active low |
| we_n | input | 1 | write enable, active low |
| oe_n | input | 1 | output enable, active low |
| addr | input | ADDR_W | multiplexed address |
| row_addr | output | ADDR_W | row of the current or last cycle |
| col_addr | output | ADDR_W | captured column |
| ref_row | output | ADDR_W | next refresh row |
| dq_oe | output | 1 | data pins should be driven |
| evt_valid | output | 1 | cycle-end pulse |
| evt_kind | output | 3 | cycle type code |
| proto_err | output | 1 | write enable changed while driving |

## Verification
On every clock the assertions check four things: the data drive only follows sampled column/output-enable/write-enable levels; standby keeps the pins quiet; an event never lasts two clocks; and a protocol error only follows a driving clock. They also check that the row is taken from the address on a plain row fall and that the refresh counter steps by exactly one on each refresh fall. Only the directed scenarios can show that each edge ordering yields the right type code. The same holds for the access event being split from the hidden refresh, for data staying held across the second row pulse, and for the counter wrapping after a full sweep of rows.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [2:0] {
    K_STBY = 3'd0,
    K_READ = 3'd1,
    K_EWR  = 3'd2,
    K_LWR  = 3'd3,
    K_RMW  = 3'd4,
    K_ROR  = 3'd5,
    K_CBR  = 3'd6,
    K_HID  = 3'd7
  } kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACC  = 2'd1,
    PH_REF  = 2'd2,
    PH_HOLD = 2'd3
  } phase_e;

  localparam int SIG_RAS = 0;
  localparam int SIG_CAS = 1;
  localparam int SIG_WE  = 2;
  localparam int NSIG    = 3;
endpackage

// File: rtl/dcd_edge_det.sv
module dcd_edge_det #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // strobes idle high, so the history resets high
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b1;
      else        prev_q[i] <= sig[i];
    end
    assign fall[i] = prev_q[i] & ~sig[i];
    assign rise[i] = ~prev_q[i] & sig[i];
  end
endmodule

// File: rtl/dcd_refresh_ctr.sv
module dcd_refresh_ctr #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dcd_addr_latch.sv
module dcd_addr_latch #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] ref_row,
  input  logic          row_ld_addr,
  input  logic          row_ld_ref,
  input  logic          col_ld,
  output logic [AW-1:0] row_addr,
  output logic [AW-1:0] col_addr
);
  logic [AW-1:0] row_q, row_d, col_q;
  logic          row_en;

  assign row_en = row_ld_addr | row_ld_ref;

  always_comb begin
    row_d = row_q;
    if (row_ld_addr)     row_d = addr;
    else if (row_ld_ref) row_d = ref_row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (row_en) row_q <= row_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      col_q <= '0;
    else if (col_ld) col_q <= addr;
  end

  assign row_addr = row_q;
  assign col_addr = col_q;
endmodule

// File: rtl/dcd_classifier.sv
module dcd_classifier
  import dcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [NSIG-1:0]  fall,
  input  logic [NSIG-1:0]  rise,
  output logic             row_ld_addr,
  output logic             row_ld_ref,
  output logic             col_ld,
  output logic             ref_inc,
  output logic             evt_valid,
  output logic [2:0]       evt_kind,
  output logic             dq_oe,
  output logic             proto_err
);
  phase_e ph_q, ph_d;
  kind_e  kind_q, kind_d, evk_q, evk_d;
  logic   live_q, live_d;     // an access is open and CAS has stayed low
  logic   early_q, early_d;   // WE was low at the CAS fall
  logic   rds_q, rds_d;       // data has been driven in this access
  logic   ev_q, ev_d;
  logic   drv_q, drv_d;
  logic   err_q, err_d;

  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall, we_chg;
  assign ras_fall = fall[SIG_RAS];
  assign ras_rise = rise[SIG_RAS];
  assign cas_fall = fall[SIG_CAS];
  assign cas_rise = rise[SIG_CAS];
  assign we_fall  = fall[SIG_WE];
  assign we_chg   = fall[SIG_WE] | rise[SIG_WE];

  always_comb begin
    ph_d        = ph_q;
    kind_d      = kind_q;
    early_d     = early_q;
    rds_d       = rds_q;
    ev_d        = 1'b0;
    evk_d       = kind_q;
    row_ld_addr = 1'b0;
    row_ld_ref  = 1'b0;
    col_ld      = 1'b0;
    ref_inc     = 1'b0;

    unique case (ph_q)
      PH_IDLE: begin
        if (ras_fall) begin
          early_d = 1'b0;
          rds_d   = 1'b0;
          if (cas_n) begin
            ph_d        = PH_ACC;
            kind_d      = K_ROR;
            row_ld_addr = 1'b1;
          end else begin
            ph_d       = PH_REF;
            kind_d     = K_CBR;
            row_ld_ref = 1'b1;
            ref_inc    = 1'b1;
          end
        end else if (cas_rise && ras_n) begin
          ev_d  = 1'b1;
          evk_d = K_STBY;
        end
      end
      PH_ACC: begin
        if (cas_fall) begin
          col_ld  = 1'b1;
          kind_d  = we_n ? K_READ : K_EWR;
          early_d = ~we_n;
          rds_d   = 1'b0;
        end else if (we_fall && !cas_n && live_q && !early_q) begin
          kind_d = rds_q ? K_RMW : K_LWR;
        end
        if (ras_rise) begin
          if (cas_n) begin
            ev_d  = 1'b1;
            evk_d = kind_d;
            ph_d  = PH_IDLE;
          end else begin
            ph_d = PH_HOLD;
          end
        end
      end
      PH_REF: begin
        if (ras_rise) begin
          if (cas_n) begin
            ev_d = 1'b1;
            ph_d = PH_IDLE;
          end else begin
            ph_d = PH_HOLD;
          end
        end
      end
      PH_HOLD: begin
        if (ras_fall) begin
          // a new row pulse with CAS held low closes the previous cycle
          ev_d       = 1'b1;
          kind_d     = live_q ? K_HID : K_CBR;
          row_ld_ref = 1'b1;
          ref_inc    = 1'b1;
          ph_d       = PH_REF;
        end else if (cas_n) begin
          ev_d = 1'b1;
          ph_d = PH_IDLE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase

    live_d = live_q;
    if (cas_n)       live_d = 1'b0;
    else if (col_ld) live_d = 1'b1;

    drv_d = live_d & ~cas_n & ~oe_n & we_n & ~early_d;
    if (drv_d) rds_d = 1'b1;
    err_d = we_chg & drv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      kind_q  <= K_STBY;
      evk_q   <= K_STBY;
      live_q  <= 1'b0;
      early_q <= 1'b0;
      rds_q   <= 1'b0;
      ev_q    <= 1'b0;
      drv_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      kind_q  <= kind_d;
      live_q  <= live_d;
      early_q <= early_d;
      rds_q   <= rds_d;
      ev_q    <= ev_d;
      drv_q   <= drv_d;
      err_q   <= err_d;
      if (ev_d) evk_q <= evk_d;
    end
  end

  assign evt_valid = ev_q;
  assign evt_kind  = evk_q;
  assign dq_oe     = drv_q;
  assign proto_err = err_q;

  // R6: drive only follows sampled CAS low, OE low, WE high
  a_r6_drive_needs_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(!cas_n && !oe_n && we_n));
  // R1: both strobes high means the pins go quiet
  a_r1_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && cas_n) |=> !dq_oe);
  // R2: a cycle-end pulse is a single clock
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);
  // R12: an error can only follow a driving clock
  a_r12_err_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(dq_oe));
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dcd_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] row_addr,
  output logic [ADDR_W-1:0] col_addr,
  output logic [ADDR_W-1:0] ref_row,
  output logic              dq_oe,
  output logic              evt_valid,
  output logic [2:0]        evt_kind,
  output logic              proto_err
);
  localparam int REF_W = ADDR_W;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NSIG-1:0] strb, fall, rise;
  assign strb[SIG_RAS] = ras_n;
  assign strb[SIG_CAS] = cas_n;
  assign strb[SIG_WE]  = we_n;

  logic row_ld_addr, row_ld_ref, col_ld, ref_inc;
  logic [REF_W-1:0] ref_cnt;

  dcd_edge_det #(.N(NSIG)) u_edge (
    .clk(clk), .rst_n(rst_int_n), .sig(strb), .fall(fall), .rise(rise)
  );

  dcd_classifier u_cls (
    .clk(clk), .rst_n(rst_int_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .fall(fall), .rise(rise),
    .row_ld_addr(row_ld_addr), .row_ld_ref(row_ld_ref),
    .col_ld(col_ld), .ref_inc(ref_inc),
    .evt_valid(evt_valid), .evt_kind(evt_kind),
    .dq_oe(dq_oe), .proto_err(proto_err)
  );

  dcd_refresh_ctr #(.W(REF_W)) u_ref (
    .clk(clk), .rst_n(rst_int_n), .inc(ref_inc), .cnt(ref_cnt)
  );

  dcd_addr_latch #(.AW(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_int_n), .addr(addr), .ref_row(ref_cnt),
    .row_ld_addr(row_ld_addr), .row_ld_ref(row_ld_ref), .col_ld(col_ld),
    .row_addr(row_addr), .col_addr(col_addr)
  );

  assign ref_row = ref_cnt;

  // R3: a plain row fall captures the address pins
  a_r3_row_from_addr: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($fell(ras_n) && cas_n) |=> (row_addr == $past(addr)));
  // R5: each refresh row fall steps the counter by one
  a_r5_ref_step: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($fell(ras_n) && !cas_n) |=> (ref_row == $past(ref_row) + REF_W'(1)));
endmodule

// File: tb/dram_cycle_decoder_tb.sv
module dram_cycle_decoder_tb_top;
  localparam int CLK_P  = 10;
  localparam int AW     = 11;
  localparam int NROWS  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] row_addr, col_addr, ref_row;
  logic dq_oe, evt_valid, proto_err;
  logic [2:0] evt_kind;

  int checks = 0, failures = 0;
  int evt_cnt = 0, err_cnt = 0;
  int last_kind = -1;
  bit drove = 1'b0;
  int exp_ref = 0;

  always #(CLK_P/2) clk = ~clk;

  dram_cycle_decoder #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .row_addr(row_addr), .col_addr(col_addr),
    .ref_row(ref_row), .dq_oe(dq_oe), .evt_valid(evt_valid),
    .evt_kind(evt_kind), .proto_err(proto_err)
  );

  always @(negedge clk) begin
    if (evt_valid) begin evt_cnt++; last_kind = int'(evt_kind); end
    if (proto_err) err_cnt++;
    if (dq_oe) drove = 1'b1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic c, input logic w,
                      input logic o, input logic [AW-1:0] a);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a;
    @(negedge clk);
  endtask

  task automatic idle(); step(1, 1, 1, 1, '0); endtask

  task automatic t_reset();
    check("R13 ref_row after reset", int'(ref_row), 0);
    check("R1 dq_oe after reset", int'(dq_oe), 0);
    check("R2 no event after reset", evt_cnt, 0);
  endtask

  task automatic t_read();
    int n0 = evt_cnt;
    idle();
    step(0, 1, 1, 1, 11'h123);
    check("R3 row latched", int'(row_addr), 'h123);
    step(0, 0, 1, 1, 11'h045);
    check("R3 col latched", int'(col_addr), 'h045);
    check("R6 no drive before OE", int'(dq_oe), 0);
    step(0, 0, 1, 0, 11'h7aa);
    check("R6 drive with CAS and OE low", int'(dq_oe), 1);
    check("R3 row unchanged", int'(row_addr), 'h123);
    check("R3 col unchanged", int'(col_addr), 'h045);
    step(1, 1, 1, 1, '0);
    check("R1 quiet at cycle end", int'(dq_oe), 0);
    idle();
    check("R2 one event for read", evt_cnt - n0, 1);
    check("R6 read type", last_kind, 1);
  endtask

  task automatic t_oe_release();
    step(0, 1, 1, 1, 11'h010);
    step(0, 0, 1, 0, 11'h011);
    step(0, 0, 1, 0, 11'h011);
    check("R7 driving before OE rise", int'(dq_oe), 1);
    step(0, 0, 1, 1, 11'h011);
    check("R7 OE high stops drive", int'(dq_oe), 0);
    step(1, 1, 1, 1, '0);
    idle();
    check("R7 cycle still a read", last_kind, 1);
  endtask

  task automatic t_ras_only();
    int n0 = evt_cnt;
    drove = 1'b0;
    step(0, 1, 1, 0, 11'h3c3);
    step(0, 1, 1, 0, 11'h000);
    step(0, 1, 0, 0, 11'h000);
    step(1, 1, 1, 1, '0);
    idle();
    check("R4 row-only type", last_kind, 5);
    check("R4 one event", evt_cnt - n0, 1);
    check("R4 never driven", int'(drove), 0);
    check("R4 row from pins", int'(row_addr), 'h3c3);
  endtask

  task automatic t_standby();
    int n0 = evt_cnt;
    step(1, 0, 1, 0, '0);
    step(1, 1, 1, 1, '0);
    idle();
    check("R1 lone CAS gives standby", last_kind, 0);
    check("R1 one standby event", evt_cnt - n0, 1);
    check("R1 lone CAS not driven", int'(dq_oe), 0);
  endtask

  task automatic t_cbr();
    int n0 = evt_cnt;
    drove = 1'b0;
    step(1, 0, 1, 0, 11'h7ff);
    step(0, 0, 1, 0, 11'h7ff);
    check("R5 row from counter", int'(row_addr), exp_ref);
    exp_ref = (exp_ref + 1) % NROWS;
    check("R5 counter advanced", int'(ref_row), exp_ref);
    step(0, 0, 1, 0, 11'h155);
    step(1, 0, 1, 0, '0);
    step(1, 1, 1, 1, '0);
    idle();
    check("R5 refresh type", last_kind, 6);
    check("R5 one event", evt_cnt - n0, 1);
    check("R5 never driven", int'(drove), 0);
  endtask

  task automatic t_early();
    drove = 1'b0;
    step(0, 1, 1, 1, 11'h200);
    step(0, 1, 0, 0, 11'h200);
    step(0, 0, 0, 0, 11'h021);
    step(0, 0, 0, 0, 11'h021);
    step(1, 1, 1, 1, '0);
    idle();
    check("R8 early write type", last_kind, 2);
    check("R8 never driven", int'(drove), 0);
    check("R8 col latched", int'(col_addr), 'h021);
  endtask

  task automatic t_late();
    drove = 1'b0;
    step(0, 1, 1, 1, 11'h201);
    step(0, 0, 1, 1, 11'h022);
    step(0, 0, 0, 1, 11'h022);
    step(0, 0, 0, 1, 11'h022);
    step(1, 1, 1, 1, '0);
    idle();
    check("R9 late write type", last_kind, 3);
    check("R9 never driven", int'(drove), 0);
  endtask

  task automatic t_rmw();
    int e0 = err_cnt;
    step(0, 1, 1, 1, 11'h202);
    step(0, 0, 1, 0, 11'h023);
    step(0, 0, 1, 0, 11'h023);
    check("R10 data read first", int'(dq_oe), 1);
    step(0, 0, 1, 1, 11'h023);
    step(0, 0, 0, 1, 11'h023);
    step(1, 1, 1, 1, '0);
    idle();
    check("R10 rmw type", last_kind, 4);
    check("R12 no error in clean rmw", err_cnt - e0, 0);
  endtask

  task automatic t_err();
    int e0 = err_cnt;
    step(0, 1, 1, 1, 11'h203);
    step(0, 0, 1, 0, 11'h024);
    step(0, 0, 1, 0, 11'h024);
    step(0, 0, 0, 0, 11'h024);
    check("R12 drive stops on WE low", int'(dq_oe), 0);
    step(1, 1, 1, 1, '0);
    idle();
    check("R12 one error pulse", err_cnt - e0, 1);
  endtask

  task automatic t_hidden();
    int n0 = evt_cnt;
    step(0, 1, 1, 1, 11'h055);
    step(0, 0, 1, 0, 11'h066);
    step(0, 0, 1, 0, 11'h066);
    step(1, 0, 1, 0, 11'h000);
    check("R11 data held across row rise", int'(dq_oe), 1);
    check("R11 no event while CAS held", evt_cnt - n0, 0);
    step(0, 0, 1, 0, 11'h444);
    check("R11 data held in refresh", int'(dq_oe), 1);
    check("R11 row from counter", int'(row_addr), exp_ref);
    exp_ref = (exp_ref + 1) % NROWS;
    check("R11 counter advanced", int'(ref_row), exp_ref);
    step(1, 0, 1, 0, '0);
    check("R11 access event at second fall", evt_cnt - n0, 1);
    check("R11 access reported as read", last_kind, 1);
    step(1, 1, 1, 1, '0);
    idle();
    check("R11 hidden type", last_kind, 7);
    check("R11 two events", evt_cnt - n0, 2);
    check("R11 drive released", int'(dq_oe), 0);
  endtask

  task automatic t_wrap();
    int todo = NROWS - exp_ref;
    for (int i = 0; i < todo; i++) begin
      step(1, 0, 1, 1, '0);
      step(0, 0, 1, 1, '0);
      step(1, 0, 1, 1, '0);
      step(1, 1, 1, 1, '0);
    end
    exp_ref = 0;
    check("R13 counter wrapped", int'(ref_row), 0);
    check("R13 last refresh type", last_kind, 6);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read();
    t_oe_release();
    t_ras_only();
    t_standby();
    t_cbr();
    t_early();
    t_late();
    t_rmw();
    t_err();
    t_hidden();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule